// File: doc/BRIEF.md
# Forward Bracket Match Scanner

This block supplies the address where a forward jump lands when the jump-target cache has no entry for an open bracket. The control logic hands it the program address of an open bracket whose current cell is zero. The scanner then walks program memory from the following address, one instruction per clock, and keeps a count of bracket nesting. When the scan reaches the close bracket that pairs with the starting open bracket, the block pulses `done_o` and returns the address just past that close bracket. In the same cycle it drives a write of the open/close address pair into the jump-target cache, so later jumps from the same bracket skip the scan.

Program memory is read through a simple address/enable port. Its read latency is a parameter: `READ_LAT` is 0 for combinational read data or 1 for data registered at the next edge. Opcode values and the last valid program address are also parameters. If the scan runs out of program memory before the pair is found, the block finishes with an error flag and does not write the cache. A start request that arrives during a scan has no effect.

Top module: `fwd_match_scanner`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `cwr_en_o` and `mem_re_o` are all low.
- R2: When `start_i` is high at a rising edge while `busy_o` is low, a scan starts. The scan reads program memory at `start_pc_i`+1, then at consecutive increasing addresses, one read per cycle. It never reads beyond `PROG_LAST`.
- R3: Nesting depth is set to one at the start. Each instruction equal to `OPEN_CODE` (default 8'h5B) raises the depth by one, and each instruction equal to `CLOSE_CODE` (default 8'h5D) lowers it by one. Any other instruction value leaves the depth unchanged. The match is the close instruction that is read while the depth is one.
- R4: With a match at address C and a scan started at P, `done_o` is high for exactly one cycle. That cycle follows rising edge number (C−P)+`READ_LAT`, counting the accepting edge as edge zero. In that cycle `target_o` equals C+1 and `err_o` is low.
- R5: In the cycle where `done_o` reports a match, `cwr_en_o` is high, `cwr_open_o` equals P and `cwr_close_o` equals C. `cwr_en_o` is low in every other cycle.
- R6: Suppose the instruction at `PROG_LAST` is read and it is not the match. Then `done_o` pulses with `err_o` high and `target_o` zero after edge (`PROG_LAST`−P)+`READ_LAT`. If a start is accepted with `start_pc_i` ≥ `PROG_LAST`, `done_o` and `err_o` go high right after the accepting edge. In both error cases `cwr_en_o` stays low, and `err_o` stays high until the next accepted start.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running scan still delivers its own result, and no additional `done_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| start_i | input | 1 | Request to begin a scan |
| start_pc_i | input | ADDR_W | Address of the open bracket |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Scan ended without a match or started out of range |
| target_o | output | ADDR_W+1 | Address just past the matching close bracket |
| mem_re_o | output | 1 | Program memory read enable |
| mem_addr_o | output | ADDR_W | Program memory read address |
| mem_data_i | input | INSTR_W | Program memory read data |
| cwr_en_o | output | 1 | Jump-target cache write enable |
| cwr_open_o | output | ADDR_W | Open bracket address to store |
| cwr_close_o | output | ADDR_W | Matching close bracket address to store |

## Verification
The latency of each result is set by the distance from the start address to the match, or to `PROG_LAST`, plus the read latency. A start address at or past `PROG_LAST` gives a fixed latency of one edge. When the driver issues a start, it computes the due cycle from that distance and places it in the scoreboard entry alongside the expected target, error flag and cache pair. The monitor compares each `done_o` pulse against both its contents and the cycle counter, so a result that arrives early or late fails. A `done_o` pulse with no pending entry is also counted as a failure. This is how the ignored mid-scan start is caught.

// File: rtl/fms_pkg.sv
package fms_pkg;

   typedef enum logic [1:0] {
      SYM_OTHER = 2'd0,
      SYM_OPEN  = 2'd1,
      SYM_CLOSE = 2'd2
   } sym_e;

endpackage

// File: rtl/fms_fetch.sv
module fms_fetch #(
   parameter int ADDR_W    = 10,
   parameter int PROG_LAST = 1023,
   parameter int READ_LAT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [ADDR_W-1:0] launch_pc,
   input  logic              halt,
   output logic              busy,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              ev_valid,
   output logic [ADDR_W-1:0] ev_addr
);

   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(PROG_LAST);

   logic [ADDR_W-1:0] nxt;
   logic              spent;
   logic              issue;

   assign issue    = busy && !spent;
   assign mem_re   = issue;
   assign mem_addr = nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         nxt   <= '0;
         spent <= 1'b0;
      end else if (launch) begin
         busy  <= 1'b1;
         nxt   <= launch_pc + 1'b1;
         spent <= 1'b0;
      end else if (halt) begin
         busy  <= 1'b0;
      end else if (issue) begin
         if (nxt == LAST_A) spent <= 1'b1;
         else               nxt   <= nxt + 1'b1;
      end
   end

   generate
      if (READ_LAT == 0) begin : g_comb_read
         assign ev_valid = issue;
         assign ev_addr  = nxt;
      end else begin : g_reg_read
         logic              pipe_v;
         logic [ADDR_W-1:0] pipe_a;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pipe_v <= 1'b0;
               pipe_a <= '0;
            end else begin
               pipe_v <= issue && !halt && !launch;
               pipe_a <= nxt;
            end
         end
         assign ev_valid = pipe_v;
         assign ev_addr  = pipe_a;
      end
   endgenerate

endmodule

// File: rtl/fms_depth.sv
module fms_depth
   import fms_pkg::*;
#(
   parameter int                 INSTR_W    = 8,
   parameter int                 DEPTH_W    = 11,
   parameter logic [INSTR_W-1:0] OPEN_CODE  = 8'h5B,
   parameter logic [INSTR_W-1:0] CLOSE_CODE = 8'h5D
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic               ev_valid,
   input  logic [INSTR_W-1:0] ev_data,
   output logic               hit
);

   localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);

   sym_e               sym;
   logic [DEPTH_W-1:0] depth;

   always_comb begin
      if (ev_data == OPEN_CODE)       sym = SYM_OPEN;
      else if (ev_data == CLOSE_CODE) sym = SYM_CLOSE;
      else                            sym = SYM_OTHER;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         depth <= '0;
      end else if (launch) begin
         depth <= ONE;
      end else if (ev_valid) begin
         case (sym)
            SYM_OPEN:  depth <= depth + ONE;
            SYM_CLOSE: depth <= depth - ONE;
            default:   depth <= depth;
         endcase
      end
   end

   assign hit = ev_valid && (sym == SYM_CLOSE) && (depth == ONE);

endmodule

// File: rtl/fms_result.sv
module fms_result #(
   parameter int ADDR_W    = 10,
   parameter int PROG_LAST = 1023
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              bad_start,
   input  logic [ADDR_W-1:0] start_pc,
   input  logic              hit,
   input  logic              ev_valid,
   input  logic [ADDR_W-1:0] ev_addr,
   output logic              halt,
   output logic              done,
   output logic              err,
   output logic [ADDR_W:0]   target,
   output logic              cwr_en,
   output logic [ADDR_W-1:0] cwr_open,
   output logic [ADDR_W-1:0] cwr_close
);

   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(PROG_LAST);

   logic [ADDR_W-1:0] origin;
   logic              tail;

   assign tail = ev_valid && !hit && (ev_addr == LAST_A);
   assign halt = hit || tail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         origin    <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         target    <= '0;
         cwr_en    <= 1'b0;
         cwr_open  <= '0;
         cwr_close <= '0;
      end else begin
         done   <= hit || tail || bad_start;
         cwr_en <= hit;
         if (accept) origin <= start_pc;
         if (accept)    err <= bad_start;
         else if (tail) err <= 1'b1;
         if (hit) begin
            target    <= {1'b0, ev_addr} + 1'b1;
            cwr_open  <= origin;
            cwr_close <= ev_addr;
         end else if (tail || bad_start) begin
            target    <= '0;
         end
      end
   end

endmodule

// File: rtl/fwd_match_scanner.sv
module fwd_match_scanner #(
   parameter int                 ADDR_W     = 10,
   parameter int                 INSTR_W    = 8,
   parameter int                 PROG_LAST  = 1023,
   parameter int                 READ_LAT   = 1,
   parameter logic [INSTR_W-1:0] OPEN_CODE  = 8'h5B,
   parameter logic [INSTR_W-1:0] CLOSE_CODE = 8'h5D
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [ADDR_W-1:0]  start_pc_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o,
   output logic [ADDR_W:0]    target_o,
   output logic               mem_re_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   input  logic [INSTR_W-1:0] mem_data_i,
   output logic               cwr_en_o,
   output logic [ADDR_W-1:0]  cwr_open_o,
   output logic [ADDR_W-1:0]  cwr_close_o
);

   localparam int                DEPTH_W = ADDR_W + 1;
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(PROG_LAST);

   generate
      if (ADDR_W < 2) begin : g_chk_addr
         $error("ADDR_W must be at least 2");
      end
      if (READ_LAT != 0 && READ_LAT != 1) begin : g_chk_lat
         $error("READ_LAT must be 0 or 1");
      end
      if (PROG_LAST < 1 || PROG_LAST >= (1 << ADDR_W)) begin : g_chk_last
         $error("PROG_LAST must lie inside the address space");
      end
      if (OPEN_CODE == CLOSE_CODE) begin : g_chk_codes
         $error("OPEN_CODE and CLOSE_CODE must differ");
      end
   endgenerate

   logic              accept;
   logic              bad_start;
   logic              launch;
   logic              halt;
   logic              hit;
   logic              ev_valid;
   logic [ADDR_W-1:0] ev_addr;

   assign accept    = start_i && !busy_o;
   assign bad_start = accept && (start_pc_i >= LAST_A);
   assign launch    = accept && !bad_start;

   fms_fetch #(
      .ADDR_W    (ADDR_W),
      .PROG_LAST (PROG_LAST),
      .READ_LAT  (READ_LAT)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .launch_pc (start_pc_i),
      .halt      (halt),
      .busy      (busy_o),
      .mem_re    (mem_re_o),
      .mem_addr  (mem_addr_o),
      .ev_valid  (ev_valid),
      .ev_addr   (ev_addr)
   );

   fms_depth #(
      .INSTR_W    (INSTR_W),
      .DEPTH_W    (DEPTH_W),
      .OPEN_CODE  (OPEN_CODE),
      .CLOSE_CODE (CLOSE_CODE)
   ) u_depth (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .ev_valid (ev_valid),
      .ev_data  (mem_data_i),
      .hit      (hit)
   );

   fms_result #(
      .ADDR_W    (ADDR_W),
      .PROG_LAST (PROG_LAST)
   ) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .bad_start (bad_start),
      .start_pc  (start_pc_i),
      .hit       (hit),
      .ev_valid  (ev_valid),
      .ev_addr   (ev_addr),
      .halt      (halt),
      .done      (done_o),
      .err       (err_o),
      .target    (target_o),
      .cwr_en    (cwr_en_o),
      .cwr_open  (cwr_open_o),
      .cwr_close (cwr_close_o)
   );

endmodule

// File: rtl/fms_checker.sv
module fms_checker #(
   parameter int ADDR_W    = 10,
   parameter int PROG_LAST = 1023
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic [ADDR_W:0]   target_o,
   input logic              mem_re_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              cwr_en_o,
   input logic [ADDR_W-1:0] cwr_open_o,
   input logic [ADDR_W-1:0] cwr_close_o
);

   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(PROG_LAST);

   a_r1_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |=> !busy_o && !done_o && !cwr_en_o && !mem_re_o);

   a_r2_reads_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |-> mem_addr_o <= LAST_A);

   a_r2_reads_ascend: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o && $past(mem_re_o) |-> mem_addr_o == $past(mem_addr_o) + 1'b1);

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> !done_o);

   a_r4_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   a_r5_write_on_success: assert property (@(posedge clk) disable iff (!rst_n)
      cwr_en_o |-> done_o && !err_o && cwr_close_o > cwr_open_o
                   && target_o == {1'b0, cwr_close_o} + 1'b1);

   a_r6_error_reported: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> done_o && !cwr_en_o);

endmodule

bind fwd_match_scanner fms_checker #(
   .ADDR_W    (ADDR_W),
   .PROG_LAST (PROG_LAST)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .target_o    (target_o),
   .mem_re_o    (mem_re_o),
   .mem_addr_o  (mem_addr_o),
   .cwr_en_o    (cwr_en_o),
   .cwr_open_o  (cwr_open_o),
   .cwr_close_o (cwr_close_o)
);

// File: tb/fwd_match_scanner_tb.sv
module fwd_match_scanner_tb;

   localparam int AW   = 6;
   localparam int LAST = 47;
   localparam int LAT  = 1;

   typedef struct {
      int tgt;
      bit err;
      int op;
      int cl;
      int due;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] start_pc_i = '0;
   logic          busy_o, done_o, err_o, mem_re_o, cwr_en_o;
   logic [AW:0]   target_o;
   logic [AW-1:0] mem_addr_o, cwr_open_o, cwr_close_o;
   logic [7:0]    rdata = 8'h00;
   logic [7:0]    mem [0:63];

   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   int   seq_bad = 0;
   int   max_addr = 0;
   bit   prev_re = 1'b0;
   int   prev_addr = 0;
   bit   finished = 1'b0;
   exp_t q[$];

   always #2 clk = ~clk;

   fwd_match_scanner #(
      .ADDR_W    (AW),
      .INSTR_W   (8),
      .PROG_LAST (LAST),
      .READ_LAT  (LAT)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_pc_i  (start_pc_i),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .err_o       (err_o),
      .target_o    (target_o),
      .mem_re_o    (mem_re_o),
      .mem_addr_o  (mem_addr_o),
      .mem_data_i  (rdata),
      .cwr_en_o    (cwr_en_o),
      .cwr_open_o  (cwr_open_o),
      .cwr_close_o (cwr_close_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_re_o) rdata <= mem[mem_addr_o];
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor: scoreboard comparison and read-order tracking (R2)
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_re_o) begin
            if (prev_re && int'(mem_addr_o) != prev_addr + 1) seq_bad++;
            if (int'(mem_addr_o) > max_addr) max_addr = int'(mem_addr_o);
         end
         prev_re   = mem_re_o;
         prev_addr = int'(mem_addr_o);
         if (done_o) begin
            if (q.size() == 0) begin
               chk(1'b0, "R7 unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(cyc == e.due, "R4 done cycle", cyc, e.due);
               chk(int'(target_o) == e.tgt, "R4 target", int'(target_o), e.tgt);
               chk(err_o == e.err, "R6 error flag", int'(err_o), int'(e.err));
               chk(cwr_en_o == !e.err, "R5 cache write enable", int'(cwr_en_o), int'(!e.err));
               if (!e.err) begin
                  chk(int'(cwr_open_o) == e.op, "R5 cache open address", int'(cwr_open_o), e.op);
                  chk(int'(cwr_close_o) == e.cl, "R5 cache close address", int'(cwr_close_o), e.cl);
               end
            end
         end else begin
            if (cwr_en_o) chk(1'b0, "R5 write outside done", 1, 0);
         end
      end
   end

   // Driver: close_at < 0 means no match before LAST
   task automatic issue(input int pc, input int close_at, input bit bad);
      exp_t e;
      @(negedge clk);
      start_i    = 1'b1;
      start_pc_i = AW'(pc);
      e.op = pc;
      e.cl = close_at;
      if (bad) begin
         e.err = 1'b1; e.tgt = 0; e.due = cyc + 1;
      end else if (close_at < 0) begin
         e.err = 1'b1; e.tgt = 0; e.due = cyc + 1 + (LAST - pc) + LAT;
      end else begin
         e.err = 1'b0; e.tgt = close_at + 1; e.due = cyc + 1 + (close_at - pc) + LAT;
      end
      q.push_back(e);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic place(input int base, input string s);
      for (int i = 0; i < s.len(); i++) mem[base + i] = s[i];
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = (i <= LAST) ? 8'h2E : 8'h5D;
      place(0,  "[+>[-]<].");
      place(10, "[]");
      place(13, "[[[]][]]");
      place(40, "[[]+++++");

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy_o && !done_o && !err_o && !cwr_en_o && !mem_re_o, "R1 reset outputs",
          int'({busy_o, done_o, err_o, cwr_en_o, mem_re_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      issue(0, 7, 1'b0);  drain();   // R3 nested pair with non-bracket ops
      issue(3, 5, 1'b0);  drain();   // R3 inner pair
      issue(10, 11, 1'b0); drain();  // R4 shortest distance
      issue(13, 20, 1'b0); drain();  // R3 two nested groups
      issue(14, 17, 1'b0); drain();
      issue(18, 19, 1'b0); drain();

      issue(40, -1, 1'b0); drain();  // R6 runs off the end
      chk(err_o == 1'b1, "R6 error held", int'(err_o), 1);
      issue(0, 7, 1'b0);   drain();  // R6 flag cleared by next start

      issue(LAST, 0, 1'b1); drain(); // R6 start at last address
      issue(50, 0, 1'b1);   drain(); // R6 start past last address

      // R7: second start during a scan is ignored
      issue(13, 20, 1'b0);
      @(negedge clk);
      start_i = 1'b1; start_pc_i = AW'(10);
      @(negedge clk);
      start_i = 1'b0;
      drain();
      repeat (5) @(negedge clk);
      chk(q.size() == 0 && !busy_o, "R7 no extra scan", int'(busy_o), 0);

      chk(seq_bad == 0, "R2 consecutive reads", seq_bad, 0);
      chk(max_addr <= LAST, "R2 read range", max_addr, LAST);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule